// File: doc/BRIEF.md
# Coherent Cache Line Controller

This block is the per-cache controller of a small direct-mapped coherent cache that follows a four-state protocol (Invalid, Shared, Exclusive, Modified). Every line holds an address tag, a data word, a two-bit state, a pending-kind bit and a busy flag. A memory address is folded into a line index by a fixed XOR hash, so each address has exactly one candidate line. Local commands (read, write, shared fetch, exclusive fetch, evict) arrive one per cycle and are checked against guards on line state, tag match and busy flag. A command whose guard fails is answered with Fail and changes nothing. The controller never stalls.

A fetch command that is accepted raises a one-cycle request toward a directory, loads the tag and marks the line busy. The directory later answers with a grant, which loads the data and the new state together, or with a deny, which only frees the line. While a line is busy it refuses every local command.

Each line runs a small state machine. Its states are LS_INV, LS_SHD, LS_EXC and LS_MOD. Its transitions are WRITE (LS_EXC/LS_MOD to LS_MOD), ISSUE (no state change, busy set), GRANT (to LS_SHD or LS_EXC, busy cleared), DENY (no state change, busy cleared) and EVICT (LS_INV/LS_SHD to LS_INV).

Top module: `cc_ctrl`

## Requirements
- R1: The line index is addr[1:0] XOR addr[3:2]. Two addresses with the same index compete for one line, so a shared fetch to a second address fails while the line is not Invalid.
- R2: After reset every line is Invalid, not busy, with tag and data zero. rsp_valid and dir_req_valid are low during reset.
- R3: Read (cmd_op 1) returns Ok with the line data in the cycle after the command, only if the line is not busy, not Invalid and its tag equals the address. Otherwise it returns Fail with rsp_rdata zero.
- R4: Write (cmd_op 2) succeeds only if the line is Exclusive (10) or Modified (11), the tag matches and the line is not busy. On success it stores the data and moves the line to Modified. A failed write changes nothing.
- R5: Shared fetch (cmd_op 3) is accepted only on a non-busy Invalid line. It loads the tag, sets busy, and in the next cycle pulses dir_req_valid with dir_req_excl=0 and dir_req_addr equal to the address.
- R6: Exclusive fetch (cmd_op 4) is accepted on a non-busy line that is Invalid, or Shared (01) with a matching tag (an upgrade). It acts as R5 but with dir_req_excl=1.
- R7: A busy line answers Fail to every command.
- R8: A directory response (dir_rsp_valid) for a busy line whose tag equals dir_rsp_addr clears busy. With dir_rsp_grant=1 it also loads dir_rsp_data, and the state becomes Shared for a shared fetch or Exclusive for an exclusive fetch. With dir_rsp_grant=0 the state is unchanged.
- R9: A directory response for a line that is not busy, or whose tag differs from dir_rsp_addr, has no effect.
- R10: Evict (cmd_op 5) succeeds only on a non-busy line that is Invalid or Shared with a matching tag, and leaves the line Invalid. Exclusive or Modified lines refuse it.
- R11: cmd_op 0 is a no-operation that produces no response. Codes 6 and 7 answer Fail. Every other valid command gets exactly one response in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Local command present |
| cmd_op | input | 3 | Command code (0 nop, 1 read, 2 write, 3 shared fetch, 4 exclusive fetch, 5 evict) |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data |
| dir_rsp_valid | input | 1 | Directory response present |
| dir_rsp_grant | input | 1 | 1 grant, 0 deny |
| dir_rsp_addr | input | ADDR_W | Address the response is for |
| dir_rsp_data | input | DATA_W | Line data carried by a grant |
| rsp_valid | output | 1 | Response to last cycle's command |
| rsp_ok | output | 1 | 1 Ok, 0 Fail |
| rsp_rdata | output | DATA_W | Read data on an Ok read, else zero |
| dir_req_valid | output | 1 | One-cycle request toward the directory |
| dir_req_excl | output | 1 | Request wants exclusive ownership |
| dir_req_addr | output | ADDR_W | Requested address |

## Verification
Directed sequences walk one line through fetch, busy refusal, grant, upgrade, write and evict. They also send a response whose tag aliases the busy line's index, which separates a correct tag compare from an index-only match. A deny is aimed at an exclusive fetch, which shows that deny frees the line without granting a state. Random commands over a 16-address space keep several indices colliding, and random directory responses interleave grants, denies and stray responses. Together they expose any guard that reads the wrong state, ignores busy, or lets a response touch a line that did not ask for it.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHD = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_state_e;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_READ    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_GET_SHD = 3'd3,
        OP_GET_EXC = 3'd4,
        OP_EVICT   = 3'd5
    } cmd_op_e;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_WRITE = 3'd1,
        EV_ISSUE = 3'd2,
        EV_EVICT = 3'd3,
        EV_GRANT = 3'd4,
        EV_DENY  = 3'd5
    } line_ev_e;

endpackage

// File: rtl/cc_index.sv
module cc_index #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    generate
        if (2 * IDX_W <= ADDR_W) begin : g_fold
            // fold the two lowest index-wide slices together
            assign idx = addr[IDX_W-1:0] ^ addr[2*IDX_W-1:IDX_W];
        end else begin : g_plain
            assign idx = addr[IDX_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cc_guard.sv
module cc_guard
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [2:0]        op,
    input  line_state_e       st,
    input  logic [ADDR_W-1:0] tag,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    output logic              ok,
    output line_ev_e          ev,
    output logic              excl
);
    logic tag_hit;
    assign tag_hit = (tag == addr);

    always_comb begin
        ok   = 1'b0;
        ev   = EV_NONE;
        excl = 1'b0;
        unique case (op)
            OP_READ: begin
                ok = !busy && (st != LS_INV) && tag_hit;
            end
            OP_WRITE: begin
                ok = !busy && tag_hit && ((st == LS_EXC) || (st == LS_MOD));
                ev = ok ? EV_WRITE : EV_NONE;
            end
            OP_GET_SHD: begin
                ok = !busy && (st == LS_INV);
                ev = ok ? EV_ISSUE : EV_NONE;
            end
            OP_GET_EXC: begin
                ok   = !busy && ((st == LS_INV) || ((st == LS_SHD) && tag_hit));
                ev   = ok ? EV_ISSUE : EV_NONE;
                excl = 1'b1;
            end
            OP_EVICT: begin
                ok = !busy && tag_hit && ((st == LS_INV) || (st == LS_SHD));
                ev = ok ? EV_EVICT : EV_NONE;
            end
            default: begin
                ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cc_line.sv
module cc_line
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_e          ev,
    input  logic              ev_excl,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    output line_state_e       st_o,
    output logic [ADDR_W-1:0] tag_o,
    output logic [DATA_W-1:0] data_o,
    output logic              busy_o
);
    line_state_e       st_q,   st_d;
    logic [ADDR_W-1:0] tag_q,  tag_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              busy_q, busy_d;
    logic              excl_q, excl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LS_INV;
            tag_q  <= '0;
            data_q <= '0;
            busy_q <= 1'b0;
            excl_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            tag_q  <= tag_d;
            data_q <= data_d;
            busy_q <= busy_d;
            excl_q <= excl_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        tag_d  = tag_q;
        data_d = data_q;
        busy_d = busy_q;
        excl_d = excl_q;
        unique case (ev)
            EV_NONE: ;
            EV_WRITE: begin
                data_d = ev_data;
                st_d   = LS_MOD;
            end
            EV_ISSUE: begin
                tag_d  = ev_addr;
                busy_d = 1'b1;
                excl_d = ev_excl;
            end
            EV_EVICT: begin
                st_d = LS_INV;
            end
            EV_GRANT: begin
                data_d = ev_data;
                st_d   = excl_q ? LS_EXC : LS_SHD;
                busy_d = 1'b0;
            end
            EV_DENY: begin
                busy_d = 1'b0;
            end
            default: ;
        endcase
    end

    assign st_o   = st_q;
    assign tag_o  = tag_q;
    assign data_o = data_q;
    assign busy_o = busy_q;
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              dir_rsp_valid,
    input  logic              dir_rsp_grant,
    input  logic [ADDR_W-1:0] dir_rsp_addr,
    input  logic [DATA_W-1:0] dir_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dir_req_valid,
    output logic              dir_req_excl,
    output logic [ADDR_W-1:0] dir_req_addr
);
    localparam int LINES = 1 << IDX_W;

    line_state_e       st_arr   [LINES];
    logic [ADDR_W-1:0] tag_arr  [LINES];
    logic [DATA_W-1:0] data_arr [LINES];
    logic [LINES-1:0]  busy_vec;

    logic [IDX_W-1:0]  cmd_idx, dir_idx;
    logic              g_ok, g_excl, dir_hit, is_fetch;
    line_ev_e          g_ev;

    cc_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cmd_idx (.addr(cmd_addr),     .idx(cmd_idx));
    cc_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dir_idx (.addr(dir_rsp_addr), .idx(dir_idx));

    cc_guard #(.ADDR_W(ADDR_W)) u_guard (
        .op   (cmd_op),
        .st   (st_arr[cmd_idx]),
        .tag  (tag_arr[cmd_idx]),
        .busy (busy_vec[cmd_idx]),
        .addr (cmd_addr),
        .ok   (g_ok),
        .ev   (g_ev),
        .excl (g_excl)
    );

    assign dir_hit  = dir_rsp_valid && busy_vec[dir_idx] && (tag_arr[dir_idx] == dir_rsp_addr);
    assign is_fetch = (cmd_op == OP_GET_SHD) || (cmd_op == OP_GET_EXC);

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            line_ev_e          ev_i;
            logic [DATA_W-1:0] dat_i;

            always_comb begin
                ev_i  = EV_NONE;
                dat_i = cmd_wdata;
                if (dir_hit && (dir_idx == IDX_W'(i))) begin
                    ev_i  = dir_rsp_grant ? EV_GRANT : EV_DENY;
                    dat_i = dir_rsp_data;
                end else if (cmd_valid && (cmd_idx == IDX_W'(i))) begin
                    ev_i = g_ev;
                end
            end

            cc_line #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_line (
                .clk     (clk),
                .rst_n   (rst_n),
                .ev      (ev_i),
                .ev_excl (g_excl),
                .ev_addr (cmd_addr),
                .ev_data (dat_i),
                .st_o    (st_arr[i]),
                .tag_o   (tag_arr[i]),
                .data_o  (data_arr[i]),
                .busy_o  (busy_vec[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_ok        <= 1'b0;
            rsp_rdata     <= '0;
            dir_req_valid <= 1'b0;
            dir_req_excl  <= 1'b0;
            dir_req_addr  <= '0;
        end else begin
            rsp_valid     <= cmd_valid && (cmd_op != OP_NOP);
            rsp_ok        <= cmd_valid && g_ok;
            rsp_rdata     <= (cmd_valid && g_ok && cmd_op == OP_READ) ? data_arr[cmd_idx] : '0;
            dir_req_valid <= cmd_valid && g_ok && is_fetch;
            dir_req_excl  <= cmd_valid && g_ok && (cmd_op == OP_GET_EXC);
            dir_req_addr  <= (cmd_valid && g_ok && is_fetch) ? cmd_addr : '0;
        end
    end
endmodule

// File: rtl/cc_ctrl_chk.sv
module cc_ctrl_chk #(
    parameter int LINES  = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              dir_req_valid,
    input logic              dir_req_excl,
    input logic              dir_rsp_valid,
    input logic [LINES-1:0]  busy_vec
);
    p_req_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dir_req_valid |-> (rsp_valid && rsp_ok));

    p_req_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dir_req_valid |-> (dir_req_excl == ($past(cmd_op) == 3'd4)));

    p_one_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(cmd_valid && (cmd_op != 3'd0)));

    p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(busy_vec & ~$past(busy_vec))) |-> dir_req_valid);

    p_busy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_vec & ~$past(busy_vec)) <= 1);

    p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~busy_vec & $past(busy_vec))) |-> $past(dir_rsp_valid));

    p_fail_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_rdata == '0));
endmodule

bind cc_ctrl cc_ctrl_chk #(.LINES(LINES), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .rsp_valid     (rsp_valid),
    .rsp_ok        (rsp_ok),
    .rsp_rdata     (rsp_rdata),
    .dir_req_valid (dir_req_valid),
    .dir_req_excl  (dir_req_excl),
    .dir_rsp_valid (dir_rsp_valid),
    .busy_vec      (busy_vec)
);

// File: tb/cc_ctrl_tb.sv
module cc_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_addr = 8'd0, cmd_wdata = 8'd0;
    logic       dir_rsp_valid = 1'b0, dir_rsp_grant = 1'b0;
    logic [7:0] dir_rsp_addr = 8'd0, dir_rsp_data = 8'd0;
    logic       rsp_valid, rsp_ok, dir_req_valid, dir_req_excl;
    logic [7:0] rsp_rdata, dir_req_addr;

    int errors = 0;
    int checks = 0;

    // reference model
    logic [1:0] m_st   [4];
    logic [7:0] m_tag  [4];
    logic [7:0] m_data [4];
    bit         m_busy [4];
    bit         m_ex   [4];

    always #10 clk = ~clk;

    cc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .dir_rsp_valid(dir_rsp_valid),
        .dir_rsp_grant(dir_rsp_grant), .dir_rsp_addr(dir_rsp_addr), .dir_rsp_data(dir_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .dir_req_valid(dir_req_valid), .dir_req_excl(dir_req_excl), .dir_req_addr(dir_req_addr)
    );

    function automatic int hidx(logic [7:0] a);
        return int'(a[1:0] ^ a[3:2]);
    endfunction

    function automatic bit cmd_ok(logic [2:0] op, logic [7:0] a);
        int  i  = hidx(a);
        bit  tm = (m_tag[i] == a);
        if (m_busy[i]) return 1'b0;
        case (op)
            3'd1: return (m_st[i] != 2'd0) && tm;
            3'd2: return (m_st[i] >= 2'd2) && tm;
            3'd3: return m_st[i] == 2'd0;
            3'd4: return (m_st[i] == 2'd0) || ((m_st[i] == 2'd1) && tm);
            3'd5: return (m_st[i] <= 2'd1) && tm;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic step(bit v, logic [2:0] op, logic [7:0] a, logic [7:0] wd,
                        bit dv, bit dg, logic [7:0] da, logic [7:0] dd, string req);
        int ci = hidx(a);
        int di = hidx(da);
        bit dhit = dv && m_busy[di] && (m_tag[di] == da);
        bit e_ok = v && cmd_ok(op, a);
        bit e_rv = v && (op != 3'd0);
        logic [7:0] e_rd = (e_ok && op == 3'd1) ? m_data[ci] : 8'd0;
        bit e_dq = e_ok && (op == 3'd3 || op == 3'd4);
        bit e_dx = e_dq && (op == 3'd4);
        logic [7:0] e_da = e_dq ? a : 8'd0;
        if (dhit) begin
            m_busy[di] = 1'b0;
            if (dg) begin
                m_data[di] = dd;
                m_st[di]   = m_ex[di] ? 2'd2 : 2'd1;
            end
        end
        if (e_ok) begin
            case (op)
                3'd2: begin m_data[ci] = wd; m_st[ci] = 2'd3; end
                3'd3: begin m_tag[ci] = a; m_busy[ci] = 1'b1; m_ex[ci] = 1'b0; end
                3'd4: begin m_tag[ci] = a; m_busy[ci] = 1'b1; m_ex[ci] = 1'b1; end
                3'd5: m_st[ci] = 2'd0;
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        dir_rsp_valid = dv; dir_rsp_grant = dg; dir_rsp_addr = da; dir_rsp_data = dd;
        @(posedge clk);
        #2;
        chk(req, "rsp_valid", {7'd0, rsp_valid}, {7'd0, e_rv});
        chk(req, "rsp_ok", {7'd0, rsp_ok}, {7'd0, e_ok});
        chk(req, "rsp_rdata", rsp_rdata, e_rd);
        chk(req, "dir_req_valid", {7'd0, dir_req_valid}, {7'd0, e_dq});
        chk(req, "dir_req_excl", {7'd0, dir_req_excl}, {7'd0, e_dx});
        chk(req, "dir_req_addr", dir_req_addr, e_da);
    endtask

    task automatic cmd(logic [2:0] op, logic [7:0] a, logic [7:0] wd, string req);
        step(1'b1, op, a, wd, 1'b0, 1'b0, 8'd0, 8'd0, req);
    endtask

    task automatic dresp(bit g, logic [7:0] a, logic [7:0] d, string req);
        step(1'b0, 3'd0, 8'd0, 8'd0, 1'b1, g, a, d, req);
    endtask

    initial begin
        #150000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 2'd0; m_tag[i] = 8'd0; m_data[i] = 8'd0; m_busy[i] = 1'b0; m_ex[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #2;
        chk("R2", "reset rsp_valid", {7'd0, rsp_valid}, 8'd0);
        chk("R2", "reset dir_req_valid", {7'd0, dir_req_valid}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        cmd(3'd1, 8'h00, 8'h00, "R2");            // read after reset fails
        cmd(3'd2, 8'h00, 8'h11, "R4");            // write to Invalid fails
        cmd(3'd3, 8'h00, 8'h00, "R5");            // shared fetch accepted
        cmd(3'd1, 8'h00, 8'h00, "R7");            // busy refuses read
        cmd(3'd4, 8'h00, 8'h00, "R7");            // busy refuses fetch
        dresp(1'b1, 8'h05, 8'h77, "R9");          // aliased tag ignored
        cmd(3'd1, 8'h00, 8'h00, "R9");            // still busy
        dresp(1'b1, 8'h00, 8'h3C, "R8");          // grant shared
        cmd(3'd1, 8'h00, 8'h00, "R3");            // read hit 3C
        cmd(3'd2, 8'h00, 8'h99, "R4");            // write to Shared fails
        cmd(3'd1, 8'h00, 8'h00, "R4");            // data unchanged
        cmd(3'd3, 8'h05, 8'h00, "R1");            // same index occupied
        cmd(3'd1, 8'h05, 8'h00, "R3");            // tag mismatch
        dresp(1'b1, 8'h00, 8'h55, "R9");          // line not busy: ignored
        cmd(3'd1, 8'h00, 8'h00, "R9");
        cmd(3'd4, 8'h00, 8'h00, "R6");            // upgrade
        dresp(1'b1, 8'h00, 8'h3C, "R8");          // grant exclusive
        cmd(3'd5, 8'h00, 8'h00, "R10");           // evict Exclusive refused
        cmd(3'd2, 8'h00, 8'hA5, "R4");            // write ok
        cmd(3'd1, 8'h00, 8'h00, "R4");            // reads A5
        cmd(3'd5, 8'h00, 8'h00, "R10");           // evict Modified refused
        cmd(3'd4, 8'h11, 8'h00, "R6");            // exclusive fetch from Invalid
        dresp(1'b0, 8'h11, 8'h00, "R8");          // deny
        cmd(3'd1, 8'h11, 8'h00, "R8");            // still Invalid
        cmd(3'd2, 8'h11, 8'h12, "R8");
        cmd(3'd6, 8'h00, 8'h00, "R11");
        cmd(3'd7, 8'h00, 8'h00, "R11");
        cmd(3'd0, 8'h00, 8'h00, "R11");
        cmd(3'd3, 8'h22, 8'h00, "R5");
        dresp(1'b1, 8'h22, 8'h4B, "R8");
        cmd(3'd5, 8'h22, 8'h00, "R10");           // evict Shared ok
        cmd(3'd1, 8'h22, 8'h00, "R10");           // now Invalid

        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [2:0] op = (r < 90) ? 3'($urandom_range(1, 5)) : 3'($urandom_range(0, 7));
            logic [7:0] a  = 8'($urandom_range(0, 15));
            bit dv = 1'b0;
            logic [7:0] da = 8'd0;
            int st = int'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0) begin
                for (int k = 0; k < 4; k++) begin
                    if (!dv && m_busy[(st + k) % 4]) begin
                        dv = 1'b1;
                        da = m_tag[(st + k) % 4];
                    end
                end
            end
            if (!dv && $urandom_range(0, 9) == 0) begin
                dv = 1'b1;
                da = 8'($urandom_range(0, 15));
            end
            step($urandom_range(0, 9) != 0, op, a, 8'($urandom), dv,
                 $urandom_range(0, 3) != 0, da, 8'($urandom), tag_of(op));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule